// File: doc/BRIEF.md
# Remote Memory Window Address Translator

This block turns a local bus address that lands in a fixed 256 MB outbound window (0x4000_0000 through 0x4FFF_FFFF) into a 32-bit link address, and then turns that link address into a 36-bit remote physical address, as the receiving side of a point-to-point memory link would. Both halves sit in one block: the transmit half and the receive half are chained back to back, so one request yields both the link address and the final remote address.

The transmit half keeps the low offset bits of the address, as set by an ignore-mask field. It can overlay the requester's 4-bit privilege ID into a chosen 4-bit field of the link address. The receive half pulls the privilege ID out of its own chosen field and clears those bits. It then splits the remaining 28-bit offset into power-of-two segments. The segment index selects one of 64 table entries, and each entry gives a remote base aligned to 4 KB. The remote address is that base plus the offset inside the segment. An entry that was never marked valid yields an error status instead of a remote address.

Requests arrive on a valid/ready channel. Results leave one cycle later from a single output register that holds its value while the consumer stalls. A simple write port loads the control fields and the segment table.

Top module: `rmw_xlate`

## Requirements
- R1: After reset, out_valid is 0, req_ready is 1, every control field is 0 and every segment entry is invalid. The first in-window request therefore reports status 2 (unmapped).
- R2: A request whose address bits [31:28] are not 4'h4 reports status 1 (outside window), with link address, remote address and privilege all 0.
- R3: The link address keeps request bits [m+16:0] and clears the bits above them, where m is the ignore-mask field. Values of m above 11 act as 11, which passes all 28 offset bits.
- R4: A transmit position k of 1..12 writes req_priv into link bits [k+19:k+16]. Position 0 writes no privilege bits. Positions above 12 act as 12, which is the top 4 bits.
- R5: A receive position r of 1..12 reads out_priv from link bits [r+19:r+16] and clears those bits before the segment decode. Position 0 gives out_priv = 0. Positions above 12 act as 12.
- R6: With segment-size field s (values above 12 act as 12), a segment covers 2^(s+16) bytes. The table index is (offset >> (s+16)) taken modulo 64, where offset is bits [27:0] of the cleared link address. s = 6 gives 4 MB segments, and s = 12 gives one 256 MB segment.
- R7: For a valid entry, out_remote_addr = {base, 12'h000} + (offset mod 2^(s+16)), computed in 36 bits. Status is 0 (ok).
- R8: An in-window request whose entry is invalid reports status 2 with out_remote_addr = 0. The link address and privilege are still reported.
- R9: req_ready = !out_valid || out_ready. An accepted request appears on the outputs at the next clock edge. While out_valid is high and out_ready is low, all outputs hold steady.
- R10: When a configuration write and an accepted request fall in the same cycle, the request is translated with the settings held before that write. The next request sees the new settings.
- R11: Write map: address 0 holds the transmit position in [3:0], the ignore mask in [7:4], the receive position in [11:8] and the segment size in [15:12]. An address with bit 6 set writes table entry cfg_addr[5:0]: wdata[31] is the valid bit and wdata[23:0] is base bits [35:12]. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 32 | Local bus address |
| req_priv | input | 4 | Requester privilege ID |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_status | output | 2 | 0 ok, 1 outside window, 2 unmapped segment |
| out_link_addr | output | 32 | Packed link address |
| out_remote_addr | output | 36 | Remote physical address |
| out_priv | output | 4 | Privilege ID recovered on the receive side |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
Two events can fall in the same cycle: a configuration write and the acceptance of a request. The bench drives a segment-table rewrite and a request to that same entry on the same clock edge. It expects the old base on that result and the new base on the request that follows. Output backpressure can also overlap a pending request. The bench holds out_ready low while a second request waits, checks that the first result stays frozen, and then checks that the second request is taken only once the stall is released. Near-exhaustive sweeps over every value of the four control fields compare each result against an arithmetic model of the requirements.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int LINK_W    = 32;
    localparam int REM_W     = 36;
    localparam int PRIV_W    = 4;
    localparam int OFS_W     = 28;
    localparam int SEG_IX_W  = 6;
    localparam int BASE_LSB  = 12;
    localparam int CFG_W     = 32;
    localparam int MIN_SHIFT = 16;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_OUTSIDE  = 2'd1,
        ST_UNMAPPED = 2'd2
    } xl_status_e;

    typedef struct packed {
        logic [3:0] seg_sel;
        logic [3:0] rx_pos;
        logic [3:0] tx_ign;
        logic [3:0] tx_pos;
    } xl_cfg_t;

    function automatic logic [3:0] clamp4(input logic [3:0] v, input logic [3:0] lim);
        return (v > lim) ? lim : v;
    endfunction
endpackage

// File: rtl/rmw_tx_overlay.sv
module rmw_tx_overlay
    import rmw_pkg::*;
#(
    parameter int          AW       = LINK_W,
    parameter int          OW       = OFS_W,
    parameter int          PW       = PRIV_W,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] priv,
    input  logic [3:0]    tx_pos,
    input  logic [3:0]    tx_ign,
    output logic          in_win,
    output logic [AW-1:0] link_addr
);
    localparam int MAX_POS = AW - PW - MIN_SHIFT;
    localparam int MAX_IGN = OW - MIN_SHIFT - 1;

    logic [3:0]    pos_c;
    logic [3:0]    ign_c;
    logic [AW-1:0] keep_mask;
    logic [AW-1:0] priv_mask;
    logic [AW-1:0] ofs;

    always_comb begin
        in_win    = (addr[AW-1:OW] == WIN_BASE[AW-1:OW]);
        ign_c     = clamp4(tx_ign, 4'(MAX_IGN));
        pos_c     = clamp4(tx_pos, 4'(MAX_POS));
        keep_mask = (AW'(1) << (ign_c + MIN_SHIFT + 1)) - AW'(1);
        ofs       = addr & keep_mask;
        priv_mask = AW'({PW{1'b1}}) << (pos_c + MIN_SHIFT);
        if (tx_pos != 4'd0) begin
            link_addr = (ofs & ~priv_mask) | (AW'(priv) << (pos_c + MIN_SHIFT));
        end else begin
            link_addr = ofs;
        end
    end
endmodule

// File: rtl/rmw_rx_segment.sv
module rmw_rx_segment
    import rmw_pkg::*;
#(
    parameter int AW  = LINK_W,
    parameter int OW  = OFS_W,
    parameter int PW  = PRIV_W,
    parameter int IXW = SEG_IX_W
) (
    input  logic [AW-1:0]  link_addr,
    input  logic [3:0]     rx_pos,
    input  logic [3:0]     seg_sel,
    output logic [PW-1:0]  priv,
    output logic [IXW-1:0] seg_idx,
    output logic [AW-1:0]  seg_ofs
);
    localparam int MAX_POS = AW - PW - MIN_SHIFT;
    localparam int MAX_SEG = OW - MIN_SHIFT;

    logic [3:0]    pos_c;
    logic [3:0]    sel_c;
    logic [AW-1:0] pmask;
    logic [AW-1:0] cleared;
    logic [AW-1:0] offset;
    logic [AW-1:0] smask;

    always_comb begin
        pos_c = clamp4(rx_pos, 4'(MAX_POS));
        sel_c = clamp4(seg_sel, 4'(MAX_SEG));
        pmask = AW'({PW{1'b1}}) << (pos_c + MIN_SHIFT);
        if (rx_pos != 4'd0) begin
            priv    = PW'(link_addr >> (pos_c + MIN_SHIFT));
            cleared = link_addr & ~pmask;
        end else begin
            priv    = '0;
            cleared = link_addr;
        end
        offset  = AW'(cleared[OW-1:0]);
        smask   = (AW'(1) << (sel_c + MIN_SHIFT)) - AW'(1);
        seg_idx = IXW'(offset >> (sel_c + MIN_SHIFT));
        seg_ofs = offset & smask;
    end
endmodule

// File: rtl/rmw_seg_table.sv
module rmw_seg_table
    import rmw_pkg::*;
#(
    parameter int IXW = SEG_IX_W,
    parameter int BW  = REM_W - BASE_LSB,
    parameter int DW  = CFG_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [IXW:0]   cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic [IXW-1:0] rd_idx,
    output xl_cfg_t        cfg,
    output logic           rd_valid,
    output logic [BW-1:0]  rd_base
);
    localparam int SEG_N = 1 << IXW;

    xl_cfg_t     cfg_d, cfg_q;
    logic        ent_valid [SEG_N];
    logic [BW-1:0] ent_base [SEG_N];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && (cfg_addr == '0)) begin
            cfg_d = xl_cfg_t'(cfg_wdata[15:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar g = 0; g < SEG_N; g++) begin : g_ent
        logic          valid_d, valid_q;
        logic [BW-1:0] base_d, base_q;

        always_comb begin
            valid_d = valid_q;
            base_d  = base_q;
            if (cfg_we && cfg_addr[IXW] && (cfg_addr[IXW-1:0] == IXW'(g))) begin
                valid_d = cfg_wdata[DW-1];
                base_d  = cfg_wdata[BW-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                base_q  <= '0;
            end else begin
                valid_q <= valid_d;
                base_q  <= base_d;
            end
        end

        assign ent_valid[g] = valid_q;
        assign ent_base[g]  = base_q;
    end

    assign cfg      = cfg_q;
    assign rd_valid = ent_valid[rd_idx];
    assign rd_base  = ent_base[rd_idx];
endmodule

// File: rtl/rmw_xlate.sv
module rmw_xlate
    import rmw_pkg::*;
#(
    parameter int          AW       = LINK_W,
    parameter int          RW       = REM_W,
    parameter int          PW       = PRIV_W,
    parameter int          OW       = OFS_W,
    parameter int          IXW      = SEG_IX_W,
    parameter int          DW       = CFG_W,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic [PW-1:0]  req_priv,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [1:0]     out_status,
    output logic [AW-1:0]  out_link_addr,
    output logic [RW-1:0]  out_remote_addr,
    output logic [PW-1:0]  out_priv,
    input  logic           cfg_we,
    input  logic [IXW:0]   cfg_addr,
    input  logic [DW-1:0]  cfg_wdata
);
    localparam int BW = RW - BASE_LSB;

    typedef struct packed {
        logic          valid;
        xl_status_e    status;
        logic [AW-1:0] link;
        logic [RW-1:0] remote;
        logic [PW-1:0] priv;
    } out_t;

    out_t out_d, out_q;

    xl_cfg_t        cfg;
    logic           in_win;
    logic [AW-1:0]  link;
    logic [PW-1:0]  rx_priv;
    logic [IXW-1:0] seg_idx;
    logic [AW-1:0]  seg_ofs;
    logic           ent_valid;
    logic [BW-1:0]  ent_base;
    logic           accept;

    rmw_seg_table #(.IXW(IXW), .BW(BW), .DW(DW)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_idx    (seg_idx),
        .cfg       (cfg),
        .rd_valid  (ent_valid),
        .rd_base   (ent_base)
    );

    rmw_tx_overlay #(.AW(AW), .OW(OW), .PW(PW), .WIN_BASE(WIN_BASE)) i_tx (
        .addr      (req_addr),
        .priv      (req_priv),
        .tx_pos    (cfg.tx_pos),
        .tx_ign    (cfg.tx_ign),
        .in_win    (in_win),
        .link_addr (link)
    );

    rmw_rx_segment #(.AW(AW), .OW(OW), .PW(PW), .IXW(IXW)) i_rx (
        .link_addr (link),
        .rx_pos    (cfg.rx_pos),
        .seg_sel   (cfg.seg_sel),
        .priv      (rx_priv),
        .seg_idx   (seg_idx),
        .seg_ofs   (seg_ofs)
    );

    assign req_ready = !out_q.valid || out_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        out_d = out_q;
        if (accept) begin
            out_d.valid = 1'b1;
            if (!in_win) begin
                out_d.status = ST_OUTSIDE;
                out_d.link   = '0;
                out_d.remote = '0;
                out_d.priv   = '0;
            end else if (!ent_valid) begin
                out_d.status = ST_UNMAPPED;
                out_d.link   = link;
                out_d.remote = '0;
                out_d.priv   = rx_priv;
            end else begin
                out_d.status = ST_OK;
                out_d.link   = link;
                out_d.remote = {ent_base, {BASE_LSB{1'b0}}} + RW'(seg_ofs);
                out_d.priv   = rx_priv;
            end
        end else if (out_ready) begin
            out_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid       = out_q.valid;
    assign out_status      = out_q.status;
    assign out_link_addr   = out_q.link;
    assign out_remote_addr = out_q.remote;
    assign out_priv        = out_q.priv;
endmodule

// File: rtl/rmw_xlate_chk.sv
module rmw_xlate_chk #(
    parameter int          AW       = 32,
    parameter int          RW       = 36,
    parameter int          PW       = 4,
    parameter int          OW       = 28,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          out_valid,
    input logic          out_ready,
    input logic [1:0]    out_status,
    input logic [AW-1:0] out_link_addr,
    input logic [RW-1:0] out_remote_addr,
    input logic [PW-1:0] out_priv
);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_status) &&
        $stable(out_link_addr) && $stable(out_remote_addr) && $stable(out_priv));

    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid);

    a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_addr[AW-1:OW] != WIN_BASE[AW-1:OW])
        |=> out_status == 2'd1);

    a_r2_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_status == 2'd1 |->
        out_link_addr == '0 && out_remote_addr == '0 && out_priv == '0);

    a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_status == 2'd2 |-> out_remote_addr == '0);

    a_r7_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_status != 2'd3);
endmodule

bind rmw_xlate rmw_xlate_chk #(.AW(AW), .RW(RW), .PW(PW), .OW(OW), .WIN_BASE(WIN_BASE)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_addr        (req_addr),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_status      (out_status),
    .out_link_addr   (out_link_addr),
    .out_remote_addr (out_remote_addr),
    .out_priv        (out_priv)
);

// File: tb/test_rmw_xlate.sv
module test_rmw_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_priv = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_status;
    logic [31:0] out_link_addr;
    logic [35:0] out_remote_addr;
    logic [3:0]  out_priv;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench copy of what was written
    logic [3:0]  m_tp, m_ig, m_rp, m_sg;
    logic        m_valid [64];
    logic [23:0] m_base  [64];

    always #10 clk = ~clk;

    rmw_xlate i_rmw_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_priv(req_priv), .out_valid(out_valid),
        .out_ready(out_ready), .out_status(out_status), .out_link_addr(out_link_addr),
        .out_remote_addr(out_remote_addr), .out_priv(out_priv), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    function automatic int lim(input logic [3:0] v, input int l);
        return (int'(v) > l) ? l : int'(v);
    endfunction

    task automatic model(input logic [31:0] a, input logic [3:0] p,
                         output logic [1:0] st, output logic [31:0] lk,
                         output logic [35:0] rem, output logic [3:0] pr);
        logic [63:0] ofs, cl, off, so;
        int k, r, s, idx;
        st = 2'd0; lk = '0; rem = '0; pr = '0;
        if (a[31:28] != 4'h4) begin
            st = 2'd1;
            return;
        end
        ofs = {32'd0, a} & ((64'd1 << (lim(m_ig, 11) + 17)) - 64'd1);
        if (m_tp != 0) begin
            k = lim(m_tp, 12) + 16;
            ofs = (ofs & ~(64'hF << k)) | (64'(p) << k);
        end
        lk = ofs[31:0];
        cl = ofs;
        if (m_rp != 0) begin
            r = lim(m_rp, 12) + 16;
            pr = 4'(cl >> r);
            cl = cl & ~(64'hF << r);
        end
        off = cl & 64'h0FFF_FFFF;
        s = lim(m_sg, 12) + 16;
        idx = int'((off >> s) & 64'd63);
        so = off & ((64'd1 << s) - 64'd1);
        if (!m_valid[idx]) begin
            st = 2'd2;
        end else begin
            rem = 36'({m_base[idx], 12'h000}) + 36'(so);
        end
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 7'd0) begin
            m_tp = d[3:0]; m_ig = d[7:4]; m_rp = d[11:8]; m_sg = d[15:12];
        end else if (a[6]) begin
            m_valid[a[5:0]] = d[31];
            m_base[a[5:0]]  = d[23:0];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [3:0] tp, ig, rp, sg);
        wr(7'd0, {16'd0, sg, rp, ig, tp});
    endtask

    // issue one request, compare the response one edge later
    task automatic xfer(input string req, input logic [31:0] a, input logic [3:0] p);
        logic [1:0] st; logic [31:0] lk; logic [35:0] rem; logic [3:0] pr;
        model(a, p, st, lk, rem, pr);
        req_valid = 1'b1; req_addr = a; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, {out_valid, out_status, pr == out_priv, lk == out_link_addr, rem == out_remote_addr},
                 {1'b1, st, 1'b1, 1'b1, 1'b1});
        if (out_status != st || out_link_addr != lk || out_remote_addr != rem || out_priv != pr)
            $display("  detail %s addr %h: st %0d/%0d link %h/%h rem %h/%h priv %h/%h",
                     req, a, out_status, st, out_link_addr, lk, out_remote_addr, rem, out_priv, pr);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin m_valid[i] = 1'b0; m_base[i] = '0; end
        m_tp = 0; m_ig = 0; m_rp = 0; m_sg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        xfer("R1 unmapped after reset", 32'h4012_3456, 4'h3);

        // program table: bases with bit 35 set
        for (int i = 0; i < 64; i++) wr(7'h40 | 7'(i), {1'b1, 7'd0, 24'h800000 + 24'(i) * 24'h01357});
        set_cfg(4'd12, 4'd11, 4'd12, 4'd6);
        // R3 R4 R5 R6 R7: 4 MB segments, priv in top nibble
        for (int i = 0; i < 64; i++) begin
            xfer("R6 R7 seg sweep low", 32'h4000_0000 + 32'(i) * 32'h40_0000, 4'(i));
            xfer("R6 R7 seg sweep high", 32'h4000_0000 + 32'(i) * 32'h40_0000 + 32'h3F_FFFF, 4'(~i));
        end

        // R2: outside window
        xfer("R2 below", 32'h3FFF_FFFF, 4'h5);
        xfer("R2 above", 32'h5000_0000, 4'h5);
        xfer("R2 zero", 32'h0000_0000, 4'hF);
        xfer("R2 top", 32'hFFFF_FFFF, 4'hA);

        // R8: invalidated entry
        wr(7'h45, 32'h0000_1234);
        xfer("R8 unmapped entry 5", 32'h4000_0000 + 5 * 32'h40_0000 + 32'h123, 4'h9);
        xfer("R8 neighbour still mapped", 32'h4000_0000 + 6 * 32'h40_0000, 4'h9);

        // R6 R7: single 256 MB segment
        set_cfg(4'd12, 4'd11, 4'd12, 4'd12);
        xfer("R6 256MB end", 32'h4FFF_FFFF, 4'h1);
        xfer("R6 256MB mid", 32'h487F_0001, 4'h2);

        // R3 R4 R5 R6: sweep every control value
        for (int tp = 0; tp < 16; tp++)
            for (int ig = 0; ig < 16; ig++)
                for (int sg = 0; sg < 16; sg++) begin
                    logic [31:0] h;
                    h = 32'(tp) * 32'h09E3_779B + 32'(ig) * 32'h085E_BCA7 + 32'(sg) * 32'h0C2B_2AE3;
                    set_cfg(4'(tp), 4'(ig), 4'(tp), 4'(sg));
                    xfer("R3 R4 R5 R6 cfg sweep", 32'h4000_0000 | (h & 32'h0FFF_FFFF), 4'(tp ^ ig));
                    xfer("R3 R4 R5 R6 cfg sweep inv", 32'h4000_0000 | (~h & 32'h0FFF_FFFF), 4'(sg));
                end
        // R5: receive position independent of transmit position
        for (int rp = 0; rp < 16; rp++) begin
            set_cfg(4'd12, 4'd11, 4'(rp), 4'd6);
            xfer("R5 rx position sweep", 32'h4A5C_3E71, 4'hB);
        end

        // R9: backpressure
        set_cfg(4'd12, 4'd11, 4'd12, 4'd6);
        begin
            logic [1:0] st; logic [31:0] lk; logic [35:0] rem; logic [3:0] pr;
            out_ready = 1'b0;
            req_valid = 1'b1; req_addr = 32'h4123_4567; req_priv = 4'h7;
            @(negedge clk);
            model(32'h4123_4567, 4'h7, st, lk, rem, pr);
            req_addr = 32'h4200_0010; req_priv = 4'h2;
            chk("R9 stall ready low", 64'(req_ready), 64'd0);
            @(negedge clk);
            chk("R9 held link", 64'(out_link_addr), 64'(lk));
            chk("R9 held remote", 64'(out_remote_addr), 64'(rem));
            chk("R9 held valid", 64'(out_valid), 64'd1);
            out_ready = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            model(32'h4200_0010, 4'h2, st, lk, rem, pr);
            chk("R9 second after release", 64'(out_remote_addr), 64'(rem));
            chk("R9 second priv", 64'(out_priv), 64'(pr));
            @(negedge clk);
            chk("R9 valid drops", 64'(out_valid), 64'd0);
        end

        // R10: same-cycle table write and request
        begin
            logic [1:0] st; logic [31:0] lk; logic [35:0] rem; logic [3:0] pr;
            model(32'h4080_0044, 4'h1, st, lk, rem, pr);
            cfg_we = 1'b1; cfg_addr = 7'h42; cfg_wdata = 32'h8000_0ABC;
            req_valid = 1'b1; req_addr = 32'h4080_0044; req_priv = 4'h1;
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            m_valid[2] = 1'b1; m_base[2] = 24'h000ABC;
            chk("R10 old base used", 64'(out_remote_addr), 64'(rem));
        end
        xfer("R10 new base next", 32'h4080_0044, 4'h1);

        // R11: writes to unmapped addresses change nothing
        begin
            logic [1:0] st; logic [31:0] lk; logic [35:0] rem; logic [3:0] pr;
            model(32'h4123_4567, 4'h6, st, lk, rem, pr);
            wr(7'h01, 32'hFFFF_FFFF);
            wr(7'h3F, 32'h0000_0000);
            xfer("R11 ignored addresses", 32'h4123_4567, 4'h6);
            chk("R11 remote unchanged", 64'(out_remote_addr), 64'(rem));
        end
        // R11: control field layout
        wr(7'h00, 32'h0000_6C0B);
        xfer("R11 field layout", 32'h4765_4321, 4'hD);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule